// File: doc/BRIEF.md
# Wired Barrier Synchronizer

This block lets a group of processors meet at a common point in their programs. Each processor owns one private "holding" flag. While any holding flag is set, a shared open-collector style line is pulled low. Once every flag has been cleared, the line floats high. Each processor reads the line back through its own status bit. Software raises its flag when work is forked, lowers it when it reaches the barrier, and then spins until its status bit reads one. An optional one-cycle release strobe per processor marks the moment the status bit rises, so a core can wake on an event rather than poll.

A processor that never raises its flag takes no part in the barrier and never delays the others. After a processor has lowered its flag, a request to raise it again is ignored until that processor has itself seen the line high. A fast core therefore cannot start the next round and trap slower cores that are still leaving the current one.

Top module: `wired_barrier_sync`

## Requirements
- R1: After a synchronous active-low reset, every holding flag (`armed_o`) reads 0, every status bit (`y_o`) reads 1 and every release strobe reads 0.
- R2: A processor whose flag is 0 and which has no unacknowledged arrival sets its flag on `arm_i`; `armed_o` shows 1 in the next cycle.
- R3: `arrive_i` clears a set flag in the next cycle. `arrive_i` on a processor whose flag is already 0 changes neither its flag nor its pending state.
- R4: In every cycle after reset, `y_o` equals 1 exactly when no flag was set in the previous cycle. The status bits therefore trail the flags by one register.
- R5: All status bits always hold the same value, so every processor sees the line rise in the same cycle.
- R6: With `REL_EN`=1, `release_o[i]` is high for exactly one cycle: the cycle in which `y_o[i]` changes from 0 to 1. With `REL_EN`=0, `release_o` stays 0.
- R7: After a processor clears its flag, its `arm_i` is ignored in every cycle in which its status bit still reads 0. The first accepted re-arm is in a cycle in which that processor's `y_o` reads 1.
- R8: A processor that is never armed never keeps the status bits low. The line rises once the armed processors have all arrived.
- R9: When `arm_i` and `arrive_i` are both high in the same cycle, a set flag is cleared and a clear flag is set, subject to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_i | input | NUM_PROC | Per-processor request to raise the holding flag (fork) |
| arrive_i | input | NUM_PROC | Per-processor request to lower the holding flag (reached barrier) |
| armed_o | output | NUM_PROC | Per-processor holding flag readback |
| y_o | output | NUM_PROC | Per-processor registered view of the shared line |
| release_o | output | NUM_PROC | Per-processor one-cycle strobe on the rising edge of `y_o` |

## Verification
The bench builds two instances. The first has four processors with the release strobe enabled. This lets rounds run with a straggler, with two cores that never take part, and with a re-arm attempt on the single cycle in which the status bit is still low after the final arrival. The second has three processors with the strobe disabled, to show that `release_o` stays at zero while the line still behaves. Random arm and arrive traffic over thousands of cycles also reaches overlapping arm/arrive requests and rounds in which a line rise coincides with a new fork.

// File: rtl/wb_pkg.sv
// Shared types for the wired barrier synchronizer.
// Assumes: nothing beyond a standard SystemVerilog package scope.
package wb_pkg;

    // Per-processor barrier state: holding flag and arrival-not-yet-seen flag.
    typedef struct packed {
        logic hold;   // pulls the shared line low while set
        logic pend;   // processor has arrived but not yet seen the line high
    } wb_slot_t;

    localparam wb_slot_t WB_SLOT_IDLE = '{hold: 1'b0, pend: 1'b0};

endpackage

// File: rtl/wb_slot.sv
// One processor's register interface to the barrier.
// Holds the flag that pulls the shared line low and a pending flag that
// blocks a new arm until the processor's own status bit has read high.
// Assumes: y_seen is this processor's registered status bit.
module wb_slot
    import wb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     arm,
    input  logic     arrive,
    input  logic     y_seen,
    output wb_slot_t state
);

    wb_slot_t st_q;

    // Update flag and pending bit; arrival on a set flag takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= WB_SLOT_IDLE;
        end else if (arrive && st_q.hold) begin
            st_q.hold <= 1'b0;
            st_q.pend <= 1'b1;
        end else begin
            if (arm && !st_q.hold && (!st_q.pend || y_seen)) begin
                st_q.hold <= 1'b1;
            end
            if (y_seen) begin
                st_q.pend <= 1'b0;
            end
        end
    end

    assign state = st_q;

endmodule

// File: rtl/wb_line.sv
// Wired-AND model of the shared barrier line.
// The line is high only when no holding flag is set. It is built as a
// chain of AND stages, one per processor, as an open-collector bus would be.
// Assumes: NUM_PROC >= 1.
module wb_line #(
    parameter int NUM_PROC = 4
) (
    input  logic [NUM_PROC-1:0] hold_vec,
    output logic                line
);

    logic [NUM_PROC:0] chain;

    assign chain[0] = 1'b1;

    // Each processor may pull the line low; none can drive it high.
    for (genvar g = 0; g < NUM_PROC; g++) begin : g_pull
        assign chain[g+1] = chain[g] & ~hold_vec[g];
    end

    assign line = chain[NUM_PROC];

endmodule

// File: rtl/wb_status.sv
// Per-processor status registers that sample the shared line, plus an
// optional one-cycle release strobe on each status bit's rising edge.
// Assumes: the line is a combinational function of registered flags.
module wb_status #(
    parameter int NUM_PROC = 4,
    parameter bit REL_EN   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line,
    output logic [NUM_PROC-1:0] y,
    output logic [NUM_PROC-1:0] rel
);

    for (genvar g = 0; g < NUM_PROC; g++) begin : g_stat
        logic y_q;

        // Sample the shared line; reset value matches a line with no flags set.
        always_ff @(posedge clk) begin
            if (!rst_n) y_q <= 1'b1;
            else        y_q <= line;
        end

        assign y[g] = y_q;

        if (REL_EN) begin : g_rel
            logic rel_q;

            // Strobe in the same cycle the status bit goes from 0 to 1.
            always_ff @(posedge clk) begin
                if (!rst_n) rel_q <= 1'b0;
                else        rel_q <= line & ~y_q;
            end

            assign rel[g] = rel_q;
        end else begin : g_norel
            assign rel[g] = 1'b0;
        end
    end

endmodule

// File: rtl/wired_barrier_sync.sv
// Top level of the wired barrier synchronizer.
// Each processor arms a holding flag at a fork and clears it on arrival.
// The shared line is high only when no flag is set, and every processor
// reads it back through a registered status bit.
// Assumes: arm/arrive come from per-processor register writes, one pulse
// per request, synchronous to clk.
module wired_barrier_sync
    import wb_pkg::*;
#(
    parameter int NUM_PROC = 4,
    parameter bit REL_EN   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PROC-1:0] arm_i,
    input  logic [NUM_PROC-1:0] arrive_i,
    output logic [NUM_PROC-1:0] armed_o,
    output logic [NUM_PROC-1:0] y_o,
    output logic [NUM_PROC-1:0] release_o
);

    wb_slot_t [NUM_PROC-1:0] slot_st;
    logic     [NUM_PROC-1:0] hold_vec;
    logic     [NUM_PROC-1:0] pend_vec;
    logic                    line;

    for (genvar g = 0; g < NUM_PROC; g++) begin : g_slot
        wb_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm    (arm_i[g]),
            .arrive (arrive_i[g]),
            .y_seen (y_o[g]),
            .state  (slot_st[g])
        );
        assign hold_vec[g] = slot_st[g].hold;
        assign pend_vec[g] = slot_st[g].pend;
    end

    wb_line #(.NUM_PROC(NUM_PROC)) u_line (
        .hold_vec (hold_vec),
        .line     (line)
    );

    wb_status #(.NUM_PROC(NUM_PROC), .REL_EN(REL_EN)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (line),
        .y     (y_o),
        .rel   (release_o)
    );

    assign armed_o = hold_vec;

endmodule

// File: rtl/wired_barrier_sync_chk.sv
// Protocol checker for wired_barrier_sync, attached with bind.
// Assumes: synchronous active-low reset; checks start one cycle after reset.
module wired_barrier_sync_chk #(
    parameter int NUM_PROC = 4,
    parameter bit REL_EN   = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PROC-1:0] arm,
    input logic [NUM_PROC-1:0] arrive,
    input logic [NUM_PROC-1:0] armed,
    input logic [NUM_PROC-1:0] y,
    input logic [NUM_PROC-1:0] rel,
    input logic [NUM_PROC-1:0] pend
);

    logic started;

    // Mark that at least one clocked reset cycle has completed.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b1;
        else        started <= started;
    end

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (($past(arm & ~armed & ~pend) & ~armed) == '0)); // R2

    AST_ARRIVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (($past(arrive & armed) & armed) == '0)); // R3

    AST_Y_TRACKS_LINE: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (y == {NUM_PROC{~|$past(armed)}})); // R4

    AST_Y_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n || !started)
        ((y == '0) || (y == '1))); // R5

    AST_REL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n || !started)
        ((rel & ~(y & ~$past(y))) == '0)); // R6

    AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !started)
        ((rel & $past(rel)) == '0)); // R6

    AST_EARLY_ARM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (($past(pend & ~y & ~armed) & armed) == '0)); // R7

    if (!REL_EN) begin : g_norel_chk
        AST_REL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n || !started)
            (rel == '0)); // R6
    end

endmodule

bind wired_barrier_sync wired_barrier_sync_chk #(
    .NUM_PROC (NUM_PROC),
    .REL_EN   (REL_EN)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm_i),
    .arrive (arrive_i),
    .armed  (armed_o),
    .y      (y_o),
    .rel    (release_o),
    .pend   (pend_vec)
);

// File: tb/wired_barrier_sync_bench.sv
`timescale 1ns/1ps
module wired_barrier_sync_bench;

    localparam int N  = 4;
    localparam int N2 = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] arm, arrive;
    logic [N-1:0] armed, y, rel;
    logic [N2-1:0] armed2, y2, rel2;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [N-1:0] m_hold, m_pend;
    logic         m_y, m_rel;

    always #2.5 clk = ~clk;

    wired_barrier_sync #(.NUM_PROC(N), .REL_EN(1'b1)) u_wired_barrier_sync (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .arrive_i(arrive),
        .armed_o(armed), .y_o(y), .release_o(rel)
    );

    wired_barrier_sync #(.NUM_PROC(N2), .REL_EN(1'b0)) u_wired_barrier_sync_norel (
        .clk(clk), .rst_n(rst_n), .arm_i(arm[N2-1:0]), .arrive_i(arrive[N2-1:0]),
        .armed_o(armed2), .y_o(y2), .release_o(rel2)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Next-state model written from the requirements.
    function automatic void model_step(input logic [N-1:0] a, input logic [N-1:0] r);
        logic [N-1:0] nh, np;
        for (int i = 0; i < N; i++) begin
            nh[i] = m_hold[i];
            np[i] = m_pend[i] & ~m_y;
            if (r[i] && m_hold[i]) begin
                nh[i] = 1'b0;
                np[i] = 1'b1;
            end else if (a[i] && !m_hold[i] && (!m_pend[i] || m_y)) begin
                nh[i] = 1'b1;
            end
        end
        m_rel  = (m_hold == '0) && !m_y;
        m_y    = (m_hold == '0);
        m_hold = nh;
        m_pend = np;
    endfunction

    task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input string tag);
        arm    = a;
        arrive = r;
        @(posedge clk);
        model_step(a, r);
        @(negedge clk);
        check(tag, armed, m_hold);
        check("R4", y, {N{m_y}});
        check("R5", {3'b0, (y == '0) || (y == '1)}, 4'b0001);
        check("R6", rel, {N{m_rel}});
        check("R6", {1'b0, rel2}, 4'b0000);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        arm = '0; arrive = '0; rst_n = 1'b0;
        m_hold = '0; m_pend = '0; m_y = 1'b1; m_rel = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", armed, '0);
        check("R1", y, '1);
        check("R1", rel, '0);
        check("R1", {1'b0, y2}, 4'b0111);
        rst_n = 1'b1;

        // Fork all four, straggler 3 arrives last.
        step(4'b1111, 4'b0000, "R2");
        check("R2", armed, 4'b1111);
        step(4'b0000, 4'b0000, "R2");
        check("R4", y, 4'b0000);
        step(4'b0000, 4'b0001, "R3");
        step(4'b0000, 4'b0010, "R3");
        step(4'b0000, 4'b0100, "R3");
        step(4'b0000, 4'b0001, "R3");   // arrive on cleared flag: no effect
        check("R3", armed, 4'b1000);
        check("R4", y, 4'b0000);
        step(4'b0000, 4'b1000, "R3");   // last arrival; line high afterwards
        check("R4", y, 4'b0000);
        // Early re-arm by processor 0 while y still low: ignored.
        step(4'b0001, 4'b0000, "R7");
        check("R7", armed, 4'b0000);
        check("R6", rel, 4'b1111);
        check("R4", y, 4'b1111);
        // Now y reads 1, re-arm accepted; strobe already gone.
        step(4'b0001, 4'b0000, "R7");
        check("R7", armed, 4'b0001);
        check("R6", rel, 4'b0000);
        step(4'b0000, 4'b0001, "R3");
        step(4'b0000, 4'b0000, "R4");
        step(4'b0000, 4'b0000, "R4");

        // Only processors 1 and 3 take part; 0 and 2 never arm.
        step(4'b1010, 4'b0000, "R8");
        step(4'b0000, 4'b0010, "R8");
        step(4'b0000, 4'b1000, "R8");
        step(4'b0000, 4'b0000, "R8");
        check("R8", y, 4'b1111);
        step(4'b0000, 4'b0000, "R8");

        // Simultaneous arm and arrive.
        step(4'b0011, 4'b0011, "R9");    // flags clear: set
        check("R9", armed, 4'b0011);
        step(4'b0001, 4'b0001, "R9");    // flag set: clear
        check("R9", armed, 4'b0010);
        step(4'b0000, 4'b0010, "R9");
        repeat (3) step(4'b0000, 4'b0000, "R4");

        // Constrained random traffic.
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] a, r;
            for (int i = 0; i < N; i++) begin
                a[i] = ($urandom_range(0, 99) < 20);
                r[i] = ($urandom_range(0, 99) < 25);
            end
            step(a, r, (k % 2) ? "R2" : "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule